// File: doc/BRIEF.md
# Ethernet Frame Header Assembler

This block sits between a packet builder and an external Ethernet controller. It takes a payload as a stream of bytes and stores the whole payload. It then sends the controller the frame body in this order: a 6-byte destination address, a 6-byte source address, a 2-byte length field, and the payload. The controller adds the preamble, the start delimiter and the CRC itself, so none of those bytes appear here.

The destination address register holds the address of the current peer. The source address register is written once at start-up with the device's factory address. Both registers are written through load ports.

A payload shorter than a configurable minimum is padded with zero bytes. The minimum is 47 by default, one more than the Ethernet floor of 46. The length field reports the payload count after padding. A payload longer than the configured maximum (1500 by default) is dropped entirely and sets a sticky error flag. No part of a dropped payload is ever sent.

Top module: `frame_header_builder`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `oversize_err` is 0.
- R2: Output bytes 0 to 5 are the destination address, with bits 47:40 first and bits 7:0 last. Bytes 6 to 11 are the source address, in the same byte order.
- R3: Output bytes 12 and 13 are the length field, high byte first. It equals the payload byte count after padding.
- R4: Starting at byte 14, the accepted payload bytes appear unchanged and in the order they arrived.
- R5: A payload shorter than `MIN_PAYLOAD` is followed by 0x00 bytes until it is `MIN_PAYLOAD` long. A payload of at least `MIN_PAYLOAD` bytes gets no padding.
- R6: `out_last` is 1 only on the final byte of a frame. After that byte is accepted, `out_valid` drops in the next cycle.
- R7: The input side accepts a byte when `in_valid` and `in_ready` are both 1. `in_ready` is low from the cycle after an accepted end-marked byte until the last output byte is accepted. While `in_ready` is high, `out_valid` is low.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` stay unchanged.
- R9: A payload of more than `MAX_PAYLOAD` bytes produces no output. `oversize_err` goes to 1 in the cycle after the payload's end-marked byte is accepted, and stays at 1 until reset.
- R10: A payload of exactly `MAX_PAYLOAD` bytes is sent in full.
- R11: An accepted byte with `in_sof` set discards any bytes collected since the last end marker. That byte becomes payload byte 0.
- R12: Pulsing `dst_load` or `src_load` replaces the matching address register. Frames that start afterwards carry the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dst_load | input | 1 | Write `dst_addr` into the destination register |
| dst_addr | input | 48 | Peer address to store |
| src_load | input | 1 | Write `src_addr` into the source register |
| src_addr | input | 48 | Device address to store |
| in_valid | input | 1 | Payload byte present |
| in_ready | output | 1 | Block can take a payload byte |
| in_data | input | 8 | Payload byte |
| in_sof | input | 1 | Byte is the first of a payload |
| in_eof | input | 1 | Byte is the last of a payload |
| out_valid | output | 1 | Frame byte present |
| out_ready | input | 1 | Controller takes the frame byte |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| oversize_err | output | 1 | Sticky: an oversize payload was dropped |

## Verification
The bench builds the block with `MAX_PAYLOAD` set to 20 and `MIN_PAYLOAD` set to 6. With these values, a padded frame, a frame at exactly the minimum, a frame at exactly the maximum and a frame one byte over the maximum all fit in a few hundred cycles. The small limits also make the buffer boundary and the padding boundary easy to reach with short payloads, including a one-byte payload. A restart in mid-payload and an address change between frames are covered with the same limits.

// File: rtl/fhb_pkg.sv
// Shared constants, types and helpers for the frame header assembler.
// Assumes 48-bit addresses sent high byte first.
package fhb_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int HDR_BYTES  = 2 * ADDR_BYTES + 2;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_SEND = 1'b1
    } fhb_state_e;

    // Return byte k of an address; k = 0 selects bits 47:40.
    function automatic logic [7:0] addr_byte(input logic [47:0] a, input logic [2:0] k);
        return a[8 * (5 - int'(k)) +: 8];
    endfunction
endpackage

// File: rtl/fhb_payload_store.sv
// Payload buffer with its write-side count.
// It stores up to MAX_PAYLOAD bytes and tracks how many bytes the current
// payload holds. It also flags when a payload grows past the limit.
// Assumes the caller gives it only accepted bytes. The read port is
// asynchronous and may be addressed past the stored count; the caller
// masks those reads.
module fhb_payload_store #(
    parameter int MAX_PAYLOAD = 1500,
    parameter int CW = $clog2(MAX_PAYLOAD + 1),
    parameter int AW = $clog2(MAX_PAYLOAD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          wr_sof,
    input  logic          wr_eof,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] next_count,
    output logic          over_next
);
    logic [7:0]    mem [MAX_PAYLOAD];
    logic [CW-1:0] count_q;
    logic          over_q;
    logic [CW-1:0] base;

    // Work out the write slot and the overflow state this byte leads to.
    always_comb begin
        base       = wr_sof ? '0 : count_q;
        over_next  = (wr_sof ? 1'b0 : over_q) | (base >= CW'(MAX_PAYLOAD));
        next_count = base + CW'(1);
    end

    // Count the bytes of the payload; clear the count at each end marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            over_q  <= 1'b0;
        end else if (wr_en) begin
            if (wr_eof) begin
                count_q <= '0;
                over_q  <= 1'b0;
            end else begin
                count_q <= over_next ? base : next_count;
                over_q  <= over_next;
            end
        end
    end

    // Store bytes that fit; bytes past the limit are not written.
    always_ff @(posedge clk) begin
        if (wr_en && !over_next)
            mem[base[AW-1:0]] <= wr_data;
    end

    // Asynchronous read for the output sequencer.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/fhb_emit_seq.sv
// Output sequencer.
// It keeps the index of the frame byte being sent and picks that byte from
// the address registers, the length field, the payload buffer or zero
// padding. Assumes MIN_PAYLOAD <= MAX_PAYLOAD, and that frm_len >= pay_len
// while a frame is being sent.
module fhb_emit_seq
    import fhb_pkg::*;
#(
    parameter int MAX_PAYLOAD = 1500,
    parameter int CW = $clog2(MAX_PAYLOAD + 1),
    parameter int AW = $clog2(MAX_PAYLOAD),
    parameter int IW = $clog2(MAX_PAYLOAD + HDR_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          adv,
    input  logic [47:0]   dst_q,
    input  logic [47:0]   src_q,
    input  logic [CW-1:0] pay_len,
    input  logic [CW-1:0] frm_len,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic [7:0]    byte_out,
    output logic          is_last
);
    logic [IW-1:0] idx_q;
    logic [IW-1:0] pos;
    logic [IW-1:0] src_k;
    logic [15:0]   len16;

    // Move through the frame one byte per output handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx_q <= '0;
        else if (start) idx_q <= '0;
        else if (adv)   idx_q <= idx_q + IW'(1);
    end

    // Select the byte for the current index.
    always_comb begin
        pos      = idx_q - IW'(HDR_BYTES);
        src_k    = idx_q - IW'(ADDR_BYTES);
        len16    = 16'(frm_len);
        rd_addr  = pos[AW-1:0];
        if (idx_q < IW'(ADDR_BYTES))
            byte_out = addr_byte(dst_q, idx_q[2:0]);
        else if (idx_q < IW'(2 * ADDR_BYTES))
            byte_out = addr_byte(src_q, src_k[2:0]);
        else if (idx_q == IW'(2 * ADDR_BYTES))
            byte_out = len16[15:8];
        else if (idx_q == IW'(2 * ADDR_BYTES + 1))
            byte_out = len16[7:0];
        else if (pos < IW'(pay_len))
            byte_out = rd_data;
        else
            byte_out = 8'h00;
        is_last = (idx_q == IW'(frm_len) + IW'(HDR_BYTES - 1));
    end
endmodule

// File: rtl/frame_header_builder.sv
// Top level of the frame header assembler.
// It collects a payload, then sends the destination address, the source
// address, the padded length and the padded payload.
// Assumes the controller downstream adds the preamble and the CRC, and that
// MIN_PAYLOAD <= MAX_PAYLOAD.
module frame_header_builder
    import fhb_pkg::*;
#(
    parameter int MAX_PAYLOAD = 1500,
    parameter int MIN_PAYLOAD = 47
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dst_load,
    input  logic [47:0] dst_addr,
    input  logic        src_load,
    input  logic [47:0] src_addr,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        oversize_err
);
    localparam int CW = $clog2(MAX_PAYLOAD + 1);
    localparam int AW = $clog2(MAX_PAYLOAD);
    localparam int IW = $clog2(MAX_PAYLOAD + HDR_BYTES + 1);
    localparam logic [CW-1:0] MIN_L = CW'(MIN_PAYLOAD);

    fhb_state_e    state_q;
    logic [47:0]   dst_q, src_q;
    logic [CW-1:0] pay_len_q, frm_len_q;
    logic          err_q;
    logic          accept, end_ok, end_bad, adv, is_last;
    logic [CW-1:0] next_count;
    logic          over_next;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data, byte_out;

    // Handshake and end-of-payload decode.
    always_comb begin
        in_ready  = (state_q == ST_FILL);
        out_valid = (state_q == ST_SEND);
        accept    = in_valid & in_ready;
        end_ok    = accept & in_eof & ~over_next;
        end_bad   = accept & in_eof & over_next;
        adv       = out_valid & out_ready;
        out_last  = is_last & out_valid;
        out_data  = byte_out;
        oversize_err = err_q;
    end

    // Address registers written through the load ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q <= '0;
            src_q <= '0;
        end else begin
            if (dst_load) dst_q <= dst_addr;
            if (src_load) src_q <= src_addr;
        end
    end

    // Collect/send state, stored lengths and the sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_FILL;
            pay_len_q <= '0;
            frm_len_q <= '0;
            err_q     <= 1'b0;
        end else begin
            if (end_bad) err_q <= 1'b1;
            case (state_q)
                ST_FILL: if (end_ok) begin
                    state_q   <= ST_SEND;
                    pay_len_q <= next_count;
                    frm_len_q <= (next_count < MIN_L) ? MIN_L : next_count;
                end
                ST_SEND: if (adv && is_last) state_q <= ST_FILL;
                default: state_q <= ST_FILL;
            endcase
        end
    end

    fhb_payload_store #(.MAX_PAYLOAD(MAX_PAYLOAD), .CW(CW), .AW(AW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (accept),
        .wr_data    (in_data),
        .wr_sof     (in_sof),
        .wr_eof     (in_eof),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .next_count (next_count),
        .over_next  (over_next)
    );

    fhb_emit_seq #(.MAX_PAYLOAD(MAX_PAYLOAD), .CW(CW), .AW(AW), .IW(IW)) u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (end_ok),
        .adv      (adv),
        .dst_q    (dst_q),
        .src_q    (src_q),
        .pay_len  (pay_len_q),
        .frm_len  (frm_len_q),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .byte_out (byte_out),
        .is_last  (is_last)
    );
endmodule

// File: rtl/fhb_checker.sv
// Property checker for the frame header assembler, attached by bind.
// Assumes only that the port signals are observable.
module fhb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       oversize_err
);
    // R7: exactly one side of the block is open at any time.
    assert_one_side_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready != out_valid);

    // R8: a stalled frame byte does not change.
    assert_hold_when_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R6: the frame closes after its last byte is taken.
    assert_frame_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R9: the error flag never clears without a reset.
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oversize_err |=> oversize_err);

    // R9: a dropped payload does not open a frame.
    assert_drop_no_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oversize_err) |-> !out_valid);
endmodule

bind frame_header_builder fhb_checker u_fhb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_last     (out_last),
    .oversize_err (oversize_err)
);

// File: tb/frame_header_builder_bench.sv
// Bench for the frame header assembler. A behavioural model built from
// queues predicts every output byte, in_ready and the error flag, and is
// compared with the design on each falling clock edge.
module frame_header_builder_bench;
    localparam int MAXP = 20;
    localparam int MINP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dst_load = 1'b0, src_load = 1'b0;
    logic [47:0] dst_addr = '0, src_addr = '0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, out_valid, out_last, oversize_err;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;

    int checks = 0;
    int errors = 0;

    logic [47:0] m_dst = '0, m_src = '0;
    logic [7:0]  exp_q[$];
    logic [7:0]  cur_q[$];
    bit          cur_ovf = 0;
    bit          err_exp = 0;
    bit          stall_mode = 0;
    int          stall_cnt = 0;
    int          out_pos = 0;
    bit          prev_stall = 0;
    logic [7:0]  prev_data = '0;
    int          last_frame_len = 0;
    int          last_len_field = 0;
    int          len_field_acc = 0;

    always #4 clk = ~clk;

    frame_header_builder #(.MAX_PAYLOAD(MAXP), .MIN_PAYLOAD(MINP)) u_frame_header_builder (
        .clk(clk), .rst_n(rst_n),
        .dst_load(dst_load), .dst_addr(dst_addr),
        .src_load(src_load), .src_addr(src_addr),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .oversize_err(oversize_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Build the whole expected frame from a finished payload.
    task automatic push_frame();
        int plen = cur_q.size();
        int flen = (plen < MINP) ? MINP : plen;
        for (int k = 0; k < 6; k++) exp_q.push_back(m_dst[8*(5-k) +: 8]);
        for (int k = 0; k < 6; k++) exp_q.push_back(m_src[8*(5-k) +: 8]);
        exp_q.push_back(8'(flen >> 8));
        exp_q.push_back(8'(flen));
        for (int k = 0; k < plen; k++) exp_q.push_back(cur_q[k]);
        for (int k = plen; k < flen; k++) exp_q.push_back(8'h00);
    endtask

    // Reference model and comparison, once per clock.
    always @(negedge clk) begin
        if (rst_n) begin
            stall_cnt++;
            out_ready = stall_mode ? (stall_cnt % 3 == 0) : 1'b1;
            chk(out_valid == (exp_q.size() != 0), "R7/R9 out_valid", int'(out_valid), int'(exp_q.size() != 0));
            chk(in_ready == (exp_q.size() == 0), "R7 in_ready", int'(in_ready), int'(exp_q.size() == 0));
            chk(oversize_err == err_exp, "R9 oversize_err", int'(oversize_err), int'(err_exp));
            if (out_valid && exp_q.size() != 0) begin
                string tag;
                if (out_pos < 12)      tag = "R2/R12 address byte";
                else if (out_pos < 14) tag = "R3 length byte";
                else if (exp_q.size() <= ((out_pos < 14) ? 0 : exp_q.size()) && exp_q[0] == 8'h00)
                                       tag = "R4/R5 payload or pad byte";
                else                   tag = "R4/R5 payload or pad byte";
                chk(out_data == exp_q[0], tag, int'(out_data), int'(exp_q[0]));
                chk(out_last == (exp_q.size() == 1), "R6 out_last", int'(out_last), int'(exp_q.size() == 1));
                if (prev_stall)
                    chk(out_data == prev_data, "R8 stalled data", int'(out_data), int'(prev_data));
                if (out_ready) begin
                    if (out_pos == 12) len_field_acc = int'(out_data) << 8;
                    if (out_pos == 13) last_len_field = len_field_acc | int'(out_data);
                    void'(exp_q.pop_front());
                    out_pos++;
                    prev_stall = 0;
                    if (exp_q.size() == 0) begin
                        last_frame_len = out_pos;
                        out_pos = 0;
                    end
                end else begin
                    prev_stall = 1;
                    prev_data = out_data;
                end
            end
            if (in_valid && in_ready) begin
                if (in_sof) begin
                    cur_q.delete();
                    cur_ovf = 0;
                end
                if (cur_q.size() >= MAXP) cur_ovf = 1;
                else cur_q.push_back(in_data);
                if (in_eof) begin
                    if (cur_ovf) err_exp = 1;
                    else push_frame();
                    cur_q.delete();
                    cur_ovf = 0;
                end
            end
        end
    end

    task automatic load_addrs(input logic [47:0] d, input logic [47:0] s);
        @(posedge clk); #2;
        dst_addr = d; src_addr = s; dst_load = 1'b1; src_load = 1'b1;
        m_dst = d; m_src = s;
        @(posedge clk); #2;
        dst_load = 1'b0; src_load = 1'b0;
    endtask

    // Drive n payload bytes, waiting on in_ready for each.
    task automatic send_pl(input int n, input int seed, input bit with_eof);
        @(posedge clk); #2;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = 8'(seed + i * 7);
            in_sof   = (i == 0);
            in_eof   = with_eof && (i == n - 1);
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk); #2;
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (exp_q.size() != 0);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(oversize_err == 1'b0, "R1 oversize_err", int'(oversize_err), 0);

        load_addrs(48'h0A1B2C3D4E5F, 48'h665544332211);    // R12
        send_pl(3, 8'h10, 1); wait_idle();                  // R5 padding
        chk(last_len_field == MINP, "R5 padded length", last_len_field, MINP);
        send_pl(6, 8'h40, 1); wait_idle();                  // exactly minimum
        chk(last_frame_len == 14 + 6, "R5 no extra pad", last_frame_len, 20);
        send_pl(1, 8'hC3, 1); wait_idle();                  // one-byte payload
        stall_mode = 1;
        send_pl(MAXP, 8'h21, 1); wait_idle();               // R10 full size
        chk(last_frame_len == 14 + MAXP, "R10 full frame", last_frame_len, 14 + MAXP);
        chk(last_len_field == MAXP, "R3 length at maximum", last_len_field, MAXP);
        stall_mode = 0;
        send_pl(MAXP + 1, 8'h33, 1);                        // R9 oversize
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R9 no frame", int'(out_valid), 0);
        chk(oversize_err == 1'b1, "R9 flag set", int'(oversize_err), 1);
        send_pl(5, 8'h55, 1); wait_idle();
        chk(oversize_err == 1'b1, "R9 flag sticky", int'(oversize_err), 1);
        send_pl(4, 8'h77, 0);                               // R11 restart
        send_pl(7, 8'h90, 1); wait_idle();
        chk(last_len_field == 7, "R11 restart length", last_len_field, 7);
        load_addrs(48'hF0E1D2C3B4A5, 48'h0123456789AB);     // R12 new addresses
        stall_mode = 1;
        send_pl(9, 8'hA0, 1); wait_idle();
        stall_mode = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule